// File: doc/BRIEF.md
# Paged Memory Bank Select Decoder

This block turns a CPU memory address into DRAM bank strobes for a memory system in which every user owns a private page of address space. Software chooses the active user by writing the page number to a single fixed I/O port. From that point each memory access is routed through a lookup table to one of four DRAM banks on this board, or to none of them. The table also supplies the two upper DRAM address bits, so a user page can be assembled from 16 KB slices of any bank.

The table index is built from three fields. The low two bits are the top two CPU address bits, inverted. The middle four bits are the latched page number. The upper three bits are the board number, read from switches. Each table entry holds four active-low bank enables and a replacement for address bits 15:14. Each enable then passes through its own per-bank switch and a global table-enable switch. A board-selected output follows the enables. Two straps modify the index and the output path. One replaces the top page-field bit with the inverted address bit 13. The other replaces DRAM address bit 14 with CPU address bit 7.

The table is a parameter. The default contents place pages 0 to 9, each 48 KB, together with a 16 KB region at 0xC000 that page 10 owns and every page shares, across two boards.

Top module: `paged_bank_decoder`

## Requirements
- R1: Reset clears the latched page number to 0.
- R2: When `io_wr` is high at a rising clock edge and `addr[7:0]` equals 0xFF, `wr_data[5:0]` is latched as the page number. A write to any other port has no effect. Only page bits 3:0 take part in the index.
- R3: A port write made while `refresh_busy` is high is ignored, and the page number keeps its value.
- R4: The table index is {board, page, seg}. Here seg = ~addr[15:14] occupies bits 1:0 and page occupies bits 5:2. The board field in bits 8:6 is the inverse of `board_sw_on`, because a switch that is on reads as 0.
- R5: Default map. Take quarter q = addr[15:14]. If q = 3, the global 16 KB chunk is g = 30. Otherwise g = 3·page + q for pages 0 to 9, and pages 10 to 15 have no chunk. The chunk is served by board g/16, bank (g mod 16)/4, with upper DRAM bits {dram_a15, dram_a14} = g mod 4. An entry with no chunk, or with a different board, enables no bank and gives upper bits 0.
- R6: At most one bit of `bank_en_n` (active low, bit i = bank i) is low at any time.
- R7: When `bank_sw_on[i]` is 0, `bank_en_n[i]` stays high.
- R8: When `map_en_sw` is 0, all enables are high and `board_sel` is low.
- R9: `board_sel` is high exactly when some bit of `bank_en_n` is low.
- R10: When `strap_a7` is 1, `dram_a14` equals `addr[7]`. When it is 0, `dram_a14` comes from the table. `dram_a15` always comes from the table.
- R11: When `strap_a13` is 1, index bit 5 equals ~addr[13] and page bit 3 is unused. When it is 0, index bit 5 equals page bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_wr | input | 1 | I/O output cycle strobe, sampled at the clock edge |
| refresh_busy | input | 1 | High while a DRAM refresh is running; blocks page writes |
| addr | input | 16 | CPU address bus |
| wr_data | input | 8 | CPU output data bus |
| board_sw_on | input | 3 | Board number switches, 1 = switch on |
| bank_sw_on | input | 4 | Per-bank enable switches, 1 = on |
| map_en_sw | input | 1 | Table enable switch, 1 = on |
| strap_a13 | input | 1 | 1 = index bit 5 taken from inverted addr[13] |
| strap_a7 | input | 1 | 1 = DRAM A14 taken from addr[7] |
| bank_en_n | output | 4 | Active-low bank enables toward the RAS logic |
| board_sel | output | 1 | Board selected, permits read data onto the bus |
| dram_a15 | output | 1 | DRAM upper address bit 15 |
| dram_a14 | output | 1 | DRAM upper address bit 14 |

## Verification
The bench builds the block with its default parameters: the 0xFF port, a six-bit page latch, and the computed two-board table. At that size the whole 512-entry index space can be visited. It sweeps all eight board numbers, all sixteen page values and all four address quarters, so every table entry is compared against an arithmetic model of the default map. Targeted sequences then cover the write-blocking cases, both straps, and the switch overrides.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

   localparam int IDX_W    = 9;
   localparam int ENT_W    = 6;
   localparam int DEPTH    = 1 << IDX_W;
   localparam int BANKS    = 4;
   localparam int PG_FLD_W = 4;
   localparam int BRD_W    = 3;
   localparam int SEG_W    = 2;

   typedef struct packed {
      logic [1:0]       hi;     // replacement for DRAM A15:A14
      logic [BANKS-1:0] en_n;   // active-low bank enables
   } map_ent_t;

   // Default map: 16 KB chunks, 30 private (pages 0..9, 3 each) + 1 shared.
   function automatic logic [DEPTH*ENT_W-1:0] build_default_map();
      logic [DEPTH*ENT_W-1:0] m;
      m = '0;
      for (int idx = 0; idx < DEPTH; idx++) begin
         int brd;
         int pg;
         int qtr;
         int chunk;
         map_ent_t e;
         brd   = (idx >> 6) & 7;
         pg    = (idx >> 2) & 15;
         qtr   = 3 - (idx & 3);
         chunk = -1;
         if (qtr == 3)     chunk = 30;
         else if (pg <= 9) chunk = pg * 3 + qtr;
         e.en_n = '1;
         e.hi   = 2'b00;
         if (chunk >= 0 && (chunk / 16) == brd) begin
            e.en_n[(chunk % 16) / 4] = 1'b0;
            e.hi = 2'(chunk % 4);
         end
         m[idx*ENT_W +: ENT_W] = e;
      end
      return m;
   endfunction

endpackage

// File: rtl/pbs_page_reg.sv
module pbs_page_reg #(
   parameter int          ADDR_W  = 16,
   parameter int          DATA_W  = 8,
   parameter int          PAGE_W  = 6,
   parameter logic [7:0]  PORT_NO = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_wr,
   input  logic              refresh_busy,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [PAGE_W-1:0] page_q
);

   initial begin
      if (PAGE_W > DATA_W) $error("page wider than data bus");
      if (ADDR_W < 8)      $error("address bus narrower than port field");
   end

   logic port_hit;
   logic load;

   assign port_hit = (addr[7:0] == PORT_NO);
   assign load     = io_wr && port_hit && !refresh_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    page_q <= '0;
      else if (load) page_q <= wr_data[PAGE_W-1:0];
   end

   p_page_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && port_hit && !refresh_busy) |=> page_q == $past(wr_data[PAGE_W-1:0]));

   p_refresh_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_busy |=> $stable(page_q));

   p_other_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !port_hit |=> $stable(page_q));

endmodule

// File: rtl/pbs_map_table.sv
module pbs_map_table #(
   parameter int                           IDX_W = pbs_pkg::IDX_W,
   parameter int                           ENT_W = pbs_pkg::ENT_W,
   parameter logic [(1<<IDX_W)*ENT_W-1:0]  MAP   = pbs_pkg::build_default_map()
) (
   input  logic [IDX_W-1:0] idx,
   output logic [ENT_W-1:0] ent
);

   localparam int DEPTH = 1 << IDX_W;

   initial begin
      if (ENT_W != pbs_pkg::ENT_W) $error("entry width mismatch");
   end

   logic [ENT_W-1:0] rows [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_row
      assign rows[i] = MAP[i*ENT_W +: ENT_W];
   end

   assign ent = rows[idx];

endmodule

// File: rtl/pbs_bank_gate.sv
module pbs_bank_gate #(
   parameter int BANKS = pbs_pkg::BANKS
) (
   input  logic [BANKS-1:0] raw_en_n,
   input  logic [1:0]       raw_hi,
   input  logic [BANKS-1:0] bank_sw_on,
   input  logic             map_en_sw,
   input  logic             strap_a7,
   input  logic             cpu_a7,
   output logic [BANKS-1:0] bank_en_n,
   output logic             board_sel,
   output logic             dram_a15,
   output logic             dram_a14
);

   initial begin
      if (BANKS < 1) $error("need at least one bank");
   end

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      assign bank_en_n[b] = raw_en_n[b] | ~bank_sw_on[b] | ~map_en_sw;
   end

   assign board_sel = ~&bank_en_n;
   assign dram_a15  = raw_hi[1];
   assign dram_a14  = strap_a7 ? cpu_a7 : raw_hi[0];

   always_comb begin
      p_single_bank_r6: assert ($onehot0(~raw_en_n) || !map_en_sw);
      if (!map_en_sw) p_map_off_r8: assert (!board_sel);
   end

endmodule

// File: rtl/paged_bank_decoder.sv
module paged_bank_decoder #(
   parameter int          ADDR_W  = 16,
   parameter int          DATA_W  = 8,
   parameter int          PAGE_W  = 6,
   parameter logic [7:0]  PORT_NO = 8'hFF,
   parameter logic [(1<<pbs_pkg::IDX_W)*pbs_pkg::ENT_W-1:0] MAP = pbs_pkg::build_default_map()
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_wr,
   input  logic              refresh_busy,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [2:0]        board_sw_on,
   input  logic [3:0]        bank_sw_on,
   input  logic              map_en_sw,
   input  logic              strap_a13,
   input  logic              strap_a7,
   output logic [3:0]        bank_en_n,
   output logic              board_sel,
   output logic              dram_a15,
   output logic              dram_a14
);

   import pbs_pkg::*;

   localparam int TOP_PG = PG_FLD_W - 1;

   initial begin
      if (BRD_W + PG_FLD_W + SEG_W != IDX_W) $error("index fields do not fill index");
      if (PAGE_W < PG_FLD_W)                 $error("page latch narrower than page field");
      if (ADDR_W != 16)                      $error("address bus must be 16 bits");
   end

   logic [PAGE_W-1:0]   page_q;
   logic [PG_FLD_W-1:0] pg_fld;
   logic [IDX_W-1:0]    idx;
   map_ent_t            ent;

   pbs_page_reg #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .PORT_NO(PORT_NO)
   ) u_page (
      .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .refresh_busy(refresh_busy),
      .addr(addr), .wr_data(wr_data), .page_q(page_q)
   );

   assign pg_fld = {strap_a13 ? ~addr[13] : page_q[TOP_PG], page_q[TOP_PG-1:0]};
   assign idx    = {~board_sw_on, pg_fld, ~addr[15:14]};

   pbs_map_table #(.IDX_W(IDX_W), .ENT_W(ENT_W), .MAP(MAP)) u_tbl (
      .idx(idx), .ent(ent)
   );

   pbs_bank_gate #(.BANKS(BANKS)) u_gate (
      .raw_en_n(ent.en_n), .raw_hi(ent.hi),
      .bank_sw_on(bank_sw_on), .map_en_sw(map_en_sw),
      .strap_a7(strap_a7), .cpu_a7(addr[7]),
      .bank_en_n(bank_en_n), .board_sel(board_sel),
      .dram_a15(dram_a15), .dram_a14(dram_a14)
   );

   always_comb begin
      p_onehot_out_r6: assert ($onehot0(~bank_en_n));
      p_sel_match_r9: assert (board_sel == (bank_en_n != 4'hF));
      for (int b = 0; b < 4; b++)
         if (!bank_sw_on[b]) p_bank_off_r7: assert (bank_en_n[b]);
      if (strap_a7) p_a7_strap_r10: assert (dram_a14 == addr[7]);
   end

endmodule

// File: tb/tb_paged_bank_decoder.sv
module tb_paged_bank_decoder;

   localparam int CLK_PERIOD = 10;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        io_wr = 0;
   logic        refresh_busy = 0;
   logic [15:0] addr = '0;
   logic [7:0]  wr_data = '0;
   logic [2:0]  board_sw_on = 3'b111;
   logic [3:0]  bank_sw_on = 4'hF;
   logic        map_en_sw = 1;
   logic        strap_a13 = 0;
   logic        strap_a7 = 0;
   logic [3:0]  bank_en_n;
   logic        board_sel;
   logic        dram_a15;
   logic        dram_a14;

   int checks = 0;
   int errors = 0;

   paged_bank_decoder dut (
      .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .refresh_busy(refresh_busy),
      .addr(addr), .wr_data(wr_data), .board_sw_on(board_sw_on),
      .bank_sw_on(bank_sw_on), .map_en_sw(map_en_sw), .strap_a13(strap_a13),
      .strap_a7(strap_a7), .bank_en_n(bank_en_n), .board_sel(board_sel),
      .dram_a15(dram_a15), .dram_a14(dram_a14)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // Expected {board_sel, a15, a14, en_n[3:0]} from the R5 map
   function automatic logic [6:0] model(int brd, int pg, int q);
      int g;
      logic [6:0] r;
      if (q == 3)      g = 30;
      else if (pg < 10) g = 3 * pg + q;
      else             g = -1;
      r = 7'b000_1111;
      if (g >= 0 && (g >> 4) == brd) begin
         r[6]   = 1'b1;
         r[5:4] = 2'(g & 3);
         r[3:0] = ~(4'b0001 << ((g & 15) >> 2));
      end
      return r;
   endfunction

   task automatic check(string req, logic [6:0] exp);
      logic [6:0] act;
      act = {board_sel, dram_a15, dram_a14, bank_en_n};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b (addr %h)", req, act, exp, addr);
      end
   endtask

   task automatic port_write(logic [7:0] port, logic [7:0] d, logic busy);
      @(negedge clk);
      addr[7:0] = port; wr_data = d; io_wr = 1; refresh_busy = busy;
      @(negedge clk);
      io_wr = 0; refresh_busy = 0;
   endtask

   task automatic set_q(int q);
      addr = 16'(q << 14);
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check("R1", model(0, 0, 0));
      rst_n = 1;
      @(negedge clk);

      // R4 R5 R2: full sweep, board field = ~switches
      for (int b = 0; b < 8; b++) begin
         board_sw_on = ~3'(b);
         for (int p = 0; p < 16; p++) begin
            port_write(8'hFF, 8'(p) | 8'hC0, 0);
            for (int q = 0; q < 4; q++) begin
               set_q(q);
               check("R5", model(b, p, q));
            end
         end
      end
      board_sw_on = 3'b111;

      // R2: other port ignored; data bits above page ignored in index
      port_write(8'hFF, 8'h35, 0);
      set_q(0); check("R2", model(0, 5, 0));
      port_write(8'hFE, 8'h01, 0);
      set_q(1); check("R2", model(0, 5, 1));
      // R3: blocked during refresh
      port_write(8'hFF, 8'h02, 1);
      set_q(2); check("R3", model(0, 5, 2));
      port_write(8'hFF, 8'h02, 0);
      set_q(2); check("R3", model(0, 2, 2));

      // R11: index bit 5 from ~A13
      strap_a13 = 1;
      addr = 16'h0000; #1; check("R11", model(0, 10, 0));
      addr = 16'h2000; #1; check("R11", model(0, 2, 0));
      port_write(8'hFF, 8'h0A, 0);
      addr = 16'h2000; #1; check("R11", model(0, 2, 0));
      strap_a13 = 0;
      addr = 16'h2000; #1; check("R11", model(0, 10, 0));

      // R10: A14 from addr[7]
      port_write(8'hFF, 8'h00, 0);
      set_q(1); check("R10", model(0, 0, 1));
      strap_a7 = 1;
      addr = 16'h4000; #1; check("R10", model(0, 0, 1) & 7'b1101111);
      addr = 16'h4080; #1; check("R10", model(0, 0, 1));
      set_q(0); addr[7] = 1; #1; check("R10", model(0, 0, 0) | 7'b0010000);
      strap_a7 = 0;

      // R7: per-bank switch
      set_q(0);
      bank_sw_on = 4'b1110; #1; check("R7", 7'b000_1111);
      bank_sw_on = 4'b0001; #1; check("R7", model(0, 0, 0));
      port_write(8'hFF, 8'h02, 0);
      set_q(0); bank_sw_on = 4'b1101; #1; check("R7", 7'b010_1111);
      bank_sw_on = 4'hF;

      // R8 R9: table enable switch
      map_en_sw = 0; #1; check("R8", 7'b010_1111);
      map_en_sw = 1; #1; check("R9", model(0, 2, 0));

      // R6 spot check with page on second board
      board_sw_on = 3'b110;
      port_write(8'hFF, 8'h07, 0);
      set_q(3); check("R6", model(1, 7, 3));

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule